// File: doc/BRIEF.md
# TDM Routing-Table Sequencer with Deferred Section Swap

This block walks a routing table for up to four time-division-multiplexed channels. Each channel has a receive lane and a transmit lane, so the default build has eight lanes. The table is held inside the block as two direction halves of 256 entries each, and each half is four banks of 64 entries. Every lane keeps an active start field and an alternate start field, each three bits wide. A field picks a start point in steps of 32 entries. When a lane receives a frame sync, it presents entries one at a time, starting at its active start. It stops after it has delivered the first entry whose last-entry flag is set.

Each lane presents its current entry on a valid/ready stream. The consumer takes an entry by raising ready while valid is high. Holding ready low is back-pressure: the lane keeps the same address and entry on its outputs and does not skip ahead. Software writes table entries, alternate start fields and swap commands through one write port. A swap command is deferred. It takes effect only when the lane's current frame has completed, or at a frame sync that arrives while the lane is idle. The swap exchanges the active and alternate start fields of that lane. Hardware then clears the command bit, so software can poll the command bits to see when the swap has happened.

Top module: `tdmseq_top`

## Requirements
- R1: After reset all lanes are idle: lane_valid is 0, every lane_addr is 0, cmd_pend is 0 and cfg_err is 0. All start fields reset to 0.
- R2: A write with wr_addr[9]=0 stores wr_data into the table. wr_addr[8] selects the direction (0 receive, 1 transmit) and wr_addr[7:0] selects the entry. Lanes 0-3 are receive channels 0-3 and lanes 4-7 are transmit channels 0-3. Each lane's lane_data shows the entry of its own direction at its lane_addr, in the same cycle.
- R3: A frame sync on an idle lane makes that lane valid in the next cycle. Its lane_addr then equals its start field times 32.
- R4: A handshake (valid and ready) on an entry that is not the last moves lane_addr up by one, modulo 256. While valid is high and ready is low, lane_addr does not change.
- R5: Bit 15 of an entry is its last-entry flag. A handshake on an entry with this flag set makes the lane idle in the next cycle. The lane starts again from its start field only at the next frame sync.
- R6: A frame sync that arrives while the lane is valid has no effect.
- R7: Writing to register select 2 (wr_addr[9]=1, wr_addr[8:2]=0, wr_addr[1:0]=2) sets command bit l for every wr_data[l] that is 1. Data bits that are 0 leave the command bits unchanged. cmd_pend shows the pending command bits.
- R8: A pending command for a lane is carried out at that lane's last-entry handshake, or at a frame sync while the lane is idle. It is never carried out at any other point in a frame. Carrying it out swaps the lane's active and alternate fields and clears its cmd_pend bit. A frame sync that carries out a swap starts the frame at the newly active field.
- R9: Register select 0 writes the receive alternate fields and select 1 writes the transmit alternate fields. Channel c's field is in wr_data[4c+2:4c]. Bit 4c+3 is reserved and ignored.
- R10: The bank of a field is its upper two bits. A write to select 0 or 1 in which two different channels have the same bank is rejected: no alternate field changes, and cfg_err goes to 1 and stays at 1 until reset.
- R11: A channel's alternate field may share a bank with the same channel's active field. Such a write is accepted and does not set cfg_err.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 10 | Write address: table entry, or register select |
| wr_data | input | 16 | Write data |
| lane_fsync | input | 8 | Frame sync, one bit per lane |
| lane_ready | input | 8 | Consumer ready, one bit per lane |
| lane_valid | output | 8 | Entry valid, one bit per lane |
| lane_addr | output | 64 | Entry index within the lane's direction, 8 bits per lane |
| lane_data | output | 128 | Entry at lane_addr, 16 bits per lane |
| cmd_pend | output | 8 | Pending swap command bits, one per lane |
| cfg_err | output | 1 | Sticky bank-conflict flag |

## Verification
A wrong lane pointer shows on lane_addr and lane_data in the cycle after the handshake that produced it. A missed or false last-entry flag shows one cycle later as a lane_valid value that is wrong. A swap carried out early, late or not at all shows at once as a cmd_pend bit changing at the wrong moment. A swap that goes to the wrong start field only shows at the next frame start, which can be a whole frame later. A wrong bank-conflict decision shows on cfg_err one cycle after the write. A wrongly accepted or rejected alternate field only shows when that lane next swaps.

// File: rtl/tdmseq_pkg.sv
package tdmseq_pkg;
  // register selects in the register half of the write address space
  typedef enum logic [1:0] {
    SEL_ALT_RX = 2'd0,
    SEL_ALT_TX = 2'd1,
    SEL_CMD    = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/tdmseq_ram.sv
module tdmseq_ram #(
  parameter int unsigned NCH   = 4,
  parameter int unsigned PTR_W = 8,
  parameter int unsigned ENT_W = 16
) (
  input  logic                   clk,
  input  logic                   we,
  input  logic                   wdir,
  input  logic [PTR_W-1:0]       waddr,
  input  logic [ENT_W-1:0]       wdata,
  input  logic [2*NCH*PTR_W-1:0] rptr,
  output logic [2*NCH*ENT_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << PTR_W;
  localparam int unsigned NLANE = 2 * NCH;

  logic [ENT_W-1:0] rx_mem [DEPTH];
  logic [ENT_W-1:0] tx_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && !wdir) rx_mem[waddr] <= wdata;
    if (we && wdir)  tx_mem[waddr] <= wdata;
  end

  // one combinational read port per lane, direction fixed by lane index
  for (genvar l = 0; l < NLANE; l++) begin : g_rd
    if (l < NCH) begin : g_rx
      assign rdata[l*ENT_W +: ENT_W] = rx_mem[rptr[l*PTR_W +: PTR_W]];
    end else begin : g_tx
      assign rdata[l*ENT_W +: ENT_W] = tx_mem[rptr[l*PTR_W +: PTR_W]];
    end
  end
endmodule

// File: rtl/tdmseq_cfg.sv
module tdmseq_cfg
  import tdmseq_pkg::*;
#(
  parameter int unsigned NCH    = 4,
  parameter int unsigned FLD_W  = 3,
  parameter int unsigned BANK_W = 2,
  parameter int unsigned DW     = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_hit,
  input  logic [1:0]             reg_sel,
  input  logic [DW-1:0]          wr_data,
  input  logic [2*NCH-1:0]       swap,
  output logic [2*NCH*FLD_W-1:0] act_flat,
  output logic [2*NCH*FLD_W-1:0] alt_flat,
  output logic [2*NCH-1:0]       cmd_q,
  output logic                   err_q
);
  localparam int unsigned NLANE = 2 * NCH;
  localparam int unsigned NIB   = FLD_W + 1;
  localparam int unsigned BLO   = FLD_W - BANK_W;

  logic [FLD_W-1:0] act_q [NLANE];
  logic [FLD_W-1:0] alt_q [NLANE];
  logic             clash;
  logic             wr_alt;
  logic             wr_cmd;
  logic             alt_dir;

  assign wr_alt  = reg_hit && (reg_sel == SEL_ALT_RX || reg_sel == SEL_ALT_TX);
  assign wr_cmd  = reg_hit && (reg_sel == SEL_CMD);
  assign alt_dir = (reg_sel == SEL_ALT_TX);

  // two different channels in one bank
  always_comb begin
    clash = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      for (int j = i + 1; j < NCH; j++) begin
        if (wr_data[i*NIB+BLO +: BANK_W] == wr_data[j*NIB+BLO +: BANK_W])
          clash = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int l = 0; l < NLANE; l++) begin
        act_q[l] <= '0;
        alt_q[l] <= '0;
      end
      cmd_q <= '0;
      err_q <= 1'b0;
    end else begin
      for (int l = 0; l < NLANE; l++) begin
        if (swap[l]) begin
          act_q[l] <= alt_q[l];
          alt_q[l] <= act_q[l];
        end
      end
      if (wr_alt && !clash) begin
        for (int c = 0; c < NCH; c++) begin
          alt_q[(alt_dir ? NCH : 0) + c] <= wr_data[c*NIB +: FLD_W];
        end
      end
      if (wr_alt && clash) err_q <= 1'b1;
      cmd_q <= (cmd_q & ~swap) | (wr_cmd ? wr_data[NLANE-1:0] : '0);
    end
  end

  for (genvar l = 0; l < NLANE; l++) begin : g_flat
    assign act_flat[l*FLD_W +: FLD_W] = act_q[l];
    assign alt_flat[l*FLD_W +: FLD_W] = alt_q[l];
  end
endmodule

// File: rtl/tdmseq_lane.sv
module tdmseq_lane #(
  parameter int unsigned PTR_W = 8,
  parameter int unsigned FLD_W = 3,
  parameter int unsigned ENT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fsync,
  input  logic             ready,
  input  logic             pend,
  input  logic [FLD_W-1:0] act_fld,
  input  logic [FLD_W-1:0] alt_fld,
  input  logic [ENT_W-1:0] ent,
  output logic             valid,
  output logic [PTR_W-1:0] ptr,
  output logic             swap
);
  localparam int unsigned OFS_W = PTR_W - FLD_W;

  logic             busy;
  logic             go;
  logic             take;
  logic             fin;
  logic [PTR_W-1:0] start;

  assign go    = fsync && !busy;
  assign take  = busy && ready;
  assign fin   = take && ent[ENT_W-1];
  assign swap  = pend && (go || fin);
  assign start = {(pend ? alt_fld : act_fld), {OFS_W{1'b0}}};
  assign valid = busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      ptr  <= '0;
    end else if (go) begin
      busy <= 1'b1;
      ptr  <= start;
    end else if (take) begin
      if (ent[ENT_W-1]) busy <= 1'b0;
      else              ptr  <= ptr + 1'b1;
    end
  end
endmodule

// File: rtl/tdmseq_top.sv
module tdmseq_top #(
  parameter int unsigned NCH        = 4,
  parameter int unsigned BANKS      = 4,
  parameter int unsigned BANK_DEPTH = 64,
  parameter int unsigned GRAN       = 32,
  parameter int unsigned ENT_W      = 16,
  localparam int unsigned NLANE     = 2 * NCH,
  localparam int unsigned DIR_DEPTH = BANKS * BANK_DEPTH,
  localparam int unsigned PTR_W     = $clog2(DIR_DEPTH),
  localparam int unsigned FLD_W     = $clog2(DIR_DEPTH / GRAN),
  localparam int unsigned BANK_W    = $clog2(BANKS),
  localparam int unsigned WA_W      = PTR_W + 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [WA_W-1:0]          wr_addr,
  input  logic [ENT_W-1:0]         wr_data,
  input  logic [NLANE-1:0]         lane_fsync,
  input  logic [NLANE-1:0]         lane_ready,
  output logic [NLANE-1:0]         lane_valid,
  output logic [NLANE*PTR_W-1:0]   lane_addr,
  output logic [NLANE*ENT_W-1:0]   lane_data,
  output logic [NLANE-1:0]         cmd_pend,
  output logic                     cfg_err
);
  logic                   reg_hit;
  logic                   ram_we;
  logic [NLANE-1:0]       swap;
  logic [NLANE*FLD_W-1:0] act_flat;
  logic [NLANE*FLD_W-1:0] alt_flat;

  assign reg_hit = wr_en && wr_addr[WA_W-1] && (wr_addr[WA_W-2:2] == '0);
  assign ram_we  = wr_en && !wr_addr[WA_W-1];

  tdmseq_cfg #(
    .NCH(NCH), .FLD_W(FLD_W), .BANK_W(BANK_W), .DW(ENT_W)
  ) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_hit  (reg_hit),
    .reg_sel  (wr_addr[1:0]),
    .wr_data  (wr_data),
    .swap     (swap),
    .act_flat (act_flat),
    .alt_flat (alt_flat),
    .cmd_q    (cmd_pend),
    .err_q    (cfg_err)
  );

  tdmseq_ram #(
    .NCH(NCH), .PTR_W(PTR_W), .ENT_W(ENT_W)
  ) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .wdir  (wr_addr[PTR_W]),
    .waddr (wr_addr[PTR_W-1:0]),
    .wdata (wr_data),
    .rptr  (lane_addr),
    .rdata (lane_data)
  );

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    tdmseq_lane #(
      .PTR_W(PTR_W), .FLD_W(FLD_W), .ENT_W(ENT_W)
    ) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .fsync   (lane_fsync[l]),
      .ready   (lane_ready[l]),
      .pend    (cmd_pend[l]),
      .act_fld (act_flat[l*FLD_W +: FLD_W]),
      .alt_fld (alt_flat[l*FLD_W +: FLD_W]),
      .ent     (lane_data[l*ENT_W +: ENT_W]),
      .valid   (lane_valid[l]),
      .ptr     (lane_addr[l*PTR_W +: PTR_W]),
      .swap    (swap[l])
    );
  end
endmodule

// File: rtl/tdmseq_chk.sv
module tdmseq_chk #(
  parameter int unsigned NLANE = 8,
  parameter int unsigned PTR_W = 8,
  parameter int unsigned OFS_W = 5,
  parameter int unsigned ENT_W = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NLANE-1:0]       lane_fsync,
  input logic [NLANE-1:0]       lane_ready,
  input logic [NLANE-1:0]       lane_valid,
  input logic [NLANE*PTR_W-1:0] lane_addr,
  input logic [NLANE*ENT_W-1:0] lane_data,
  input logic [NLANE-1:0]       cmd_pend,
  input logic                   cfg_err
);
  for (genvar l = 0; l < NLANE; l++) begin : g_chk
    // R4
    backpressure_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lane_valid[l] && !lane_ready[l]
      |=> lane_valid[l] && $stable(lane_addr[l*PTR_W +: PTR_W]));

    // R4
    step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lane_valid[l] && lane_ready[l] && !lane_data[l*ENT_W+ENT_W-1]
      |=> lane_valid[l] &&
          lane_addr[l*PTR_W +: PTR_W] == PTR_W'($past(lane_addr[l*PTR_W +: PTR_W]) + 1'b1));

    // R5
    frame_end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lane_valid[l] && lane_ready[l] && lane_data[l*ENT_W+ENT_W-1]
      |=> !lane_valid[l]);

    // R3
    frame_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lane_valid[l] && lane_fsync[l]
      |=> lane_valid[l] && lane_addr[l*PTR_W +: OFS_W] == '0);

    // R3
    idle_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lane_valid[l] && !lane_fsync[l] |=> !lane_valid[l]);

    // R8
    swap_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cmd_pend[l])
      |-> $past(lane_fsync[l] && !lane_valid[l]) ||
          $past(lane_valid[l] && lane_ready[l] && lane_data[l*ENT_W+ENT_W-1]));
  end

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);
endmodule

bind tdmseq_top tdmseq_chk #(
  .NLANE(NLANE), .PTR_W(PTR_W), .OFS_W(PTR_W - FLD_W), .ENT_W(ENT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lane_fsync (lane_fsync),
  .lane_ready (lane_ready),
  .lane_valid (lane_valid),
  .lane_addr  (lane_addr),
  .lane_data  (lane_data),
  .cmd_pend   (cmd_pend),
  .cfg_err    (cfg_err)
);

// File: tb/tdmseq_top_bench.sv
module tdmseq_top_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [9:0]   wr_addr = '0;
  logic [15:0]  wr_data = '0;
  logic [7:0]   lane_fsync = '0;
  logic [7:0]   lane_ready = '0;
  logic [7:0]   lane_valid;
  logic [63:0]  lane_addr;
  logic [127:0] lane_data;
  logic [7:0]   cmd_pend;
  logic         cfg_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // bench model state
  bit [15:0] mm [2][256];
  bit [2:0]  ma [8];
  bit [2:0]  ms [8];
  bit [7:0]  mc;
  bit        me;
  bit        mb [8];
  bit [7:0]  mp [8];

  always #4 clk = ~clk;

  tdmseq_top u_tdmseq_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .lane_fsync(lane_fsync), .lane_ready(lane_ready), .lane_valid(lane_valid),
    .lane_addr(lane_addr), .lane_data(lane_data), .cmd_pend(cmd_pend), .cfg_err(cfg_err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit clash(input bit [15:0] v);
    for (int i = 0; i < 4; i++)
      for (int j = i + 1; j < 4; j++)
        if (v[4*i+1 +: 2] == v[4*j+1 +: 2]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit [7:0] laddr(input int l);
    return lane_addr[l*8 +: 8];
  endfunction

  task automatic check_all();
    for (int l = 0; l < 8; l++) begin
      chk(lane_valid[l] == mb[l], $sformatf("R5 valid lane%0d", l), lane_valid[l], mb[l]);
      chk(laddr(l) == mp[l], $sformatf("R4 addr lane%0d", l), laddr(l), mp[l]);
      chk(lane_data[l*16 +: 16] == mm[l/4][mp[l]], $sformatf("R2 data lane%0d", l),
          lane_data[l*16 +: 16], mm[l/4][mp[l]]);
    end
    chk(cmd_pend == mc, "R8 cmd_pend", cmd_pend, mc);
    chk(cfg_err == me, "R10 cfg_err", cfg_err, me);
  endtask

  // one clock: compute model next state, step, then compare at negedge
  task automatic tick();
    bit [2:0]  na [8];
    bit [2:0]  ns [8];
    bit        nb [8];
    bit [7:0]  np [8];
    bit [7:0]  sw;
    bit [7:0]  nc;
    bit        ne;
    bit [15:0] ent;
    bit        go;
    bit        tk;
    bit        rwe;
    sw = '0;
    for (int l = 0; l < 8; l++) begin
      na[l] = ma[l]; ns[l] = ms[l]; nb[l] = mb[l]; np[l] = mp[l];
      ent = mm[l/4][mp[l]];
      go = lane_fsync[l] && !mb[l];
      tk = mb[l] && lane_ready[l];
      sw[l] = mc[l] && (go || (tk && ent[15]));
      if (go) begin
        nb[l] = 1'b1;
        np[l] = {(mc[l] ? ms[l] : ma[l]), 5'b0};
      end else if (tk) begin
        if (ent[15]) nb[l] = 1'b0;
        else np[l] = mp[l] + 8'd1;
      end
      if (sw[l]) begin
        na[l] = ms[l];
        ns[l] = ma[l];
      end
    end
    nc = mc & ~sw;
    ne = me;
    if (wr_en && wr_addr[9] && wr_addr[8:2] == '0) begin
      if (wr_addr[1:0] < 2'd2) begin
        if (clash(wr_data)) ne = 1'b1;
        else for (int c = 0; c < 4; c++) ns[wr_addr[0]*4 + c] = wr_data[4*c +: 3];
      end else if (wr_addr[1:0] == 2'd2) begin
        nc = nc | wr_data[7:0];
      end
    end
    rwe = wr_en && !wr_addr[9];
    @(posedge clk);
    for (int l = 0; l < 8; l++) begin
      ma[l] = na[l]; ms[l] = ns[l]; mb[l] = nb[l]; mp[l] = np[l];
    end
    mc = nc;
    me = ne;
    if (rwe) mm[wr_addr[8]][wr_addr[7:0]] = wr_data;
    @(negedge clk);
    wr_en = 1'b0;
    lane_fsync = '0;
    check_all();
  endtask

  task automatic wr(input bit [9:0] a, input bit [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
  endtask

  task automatic sync(input int l);
    lane_fsync[l] = 1'b1;
    tick();
  endtask

  function automatic bit [15:0] good_alt();
    bit [1:0] r;
    bit [15:0] v;
    r = 2'($urandom_range(0, 3));
    v = '0;
    for (int c = 0; c < 4; c++)
      v[4*c +: 4] = {1'($urandom_range(0, 1)), 2'(c + r), 1'($urandom_range(0, 1))};
    return v;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    int seed;
    seed = $urandom(32'd2024);
    mc = '0; me = 1'b0;
    for (int l = 0; l < 8; l++) begin
      ma[l] = '0; ms[l] = '0; mb[l] = 1'b0; mp[l] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk(lane_valid == 8'h00, "R1 valid after reset", lane_valid, 0);
    chk(lane_addr == 64'h0, "R1 addr after reset", 0, 0);
    chk(cmd_pend == 8'h00, "R1 cmd after reset", cmd_pend, 0);
    chk(cfg_err == 1'b0, "R1 err after reset", cfg_err, 0);

    // R2 fill table: rx frames end at offset 3, tx at offset 5 of each 32 block
    for (int d = 0; d < 2; d++)
      for (int i = 0; i < 256; i++)
        wr({1'b0, 1'(d), 8'(i)},
           {((d == 0) ? (i % 32 == 3) : (i % 32 == 5)), 6'(d * 5), 1'b0, 8'(i)});

    // R3 start at field 0
    lane_ready = '0;
    sync(0);
    chk(lane_valid[0] && laddr(0) == 8'd0, "R3 frame start lane0", laddr(0), 0);
    // R4 back-pressure holds
    tick(); tick();
    chk(laddr(0) == 8'd0, "R4 hold under back-pressure", laddr(0), 0);
    lane_ready[0] = 1'b1; tick(); lane_ready[0] = 1'b0;
    chk(laddr(0) == 8'd1, "R4 step after handshake", laddr(0), 1);
    chk(lane_data[15:0] == 16'h0001, "R2 entry shown", lane_data[15:0], 16'h0001);
    // R6 sync during frame ignored
    sync(0);
    chk(laddr(0) == 8'd1 && lane_valid[0], "R6 mid-frame sync ignored", laddr(0), 1);
    // R5 end of frame
    lane_ready[0] = 1'b1;
    tick(); tick(); tick();
    chk(!lane_valid[0], "R5 idle after last entry", lane_valid[0], 0);
    chk(laddr(0) == 8'd3, "R5 addr parked on last", laddr(0), 3);
    // R9 alternate fields with reserved bits set: ch0=5 ch1=1 ch2=3 ch3=6
    wr(10'h200, 16'hEB9D);
    chk(!cfg_err, "R9 valid layout accepted", cfg_err, 0);
    // R7 command set, zero write has no effect
    wr(10'h202, 16'h0001);
    chk(cmd_pend == 8'h01, "R7 command bit set", cmd_pend, 1);
    wr(10'h202, 16'h0000);
    chk(cmd_pend == 8'h01, "R7 zero write keeps bits", cmd_pend, 1);
    // R8 swap at sync on idle lane
    sync(0);
    chk(laddr(0) == 8'd160, "R8 R9 swapped start", laddr(0), 160);
    chk(cmd_pend[0] == 1'b0, "R8 command cleared at sync", cmd_pend[0], 0);
    // R8 mid-frame request waits for last entry
    wr(10'h202, 16'h0001);
    tick();
    chk(cmd_pend[0] == 1'b1, "R8 no swap mid-frame", cmd_pend[0], 1);
    while (lane_valid[0]) tick();
    chk(cmd_pend[0] == 1'b0, "R8 command cleared at frame end", cmd_pend[0], 0);
    sync(0);
    chk(laddr(0) == 8'd0, "R8 swapped back start", laddr(0), 0);
    while (lane_valid[0]) tick();
    // R11 same-channel same-bank: ch0=1 ch1=2 ch2=4 ch3=6
    wr(10'h200, 16'h6421);
    chk(!cfg_err, "R11 same-channel bank share accepted", cfg_err, 0);
    // R10 clash rejected: ch1 and ch2 both in bank 0
    wr(10'h200, 16'h0015);
    chk(cfg_err, "R10 clash flagged", cfg_err, 1);
    wr(10'h200, 16'h6421);
    chk(cfg_err, "R10 flag sticky", cfg_err, 1);
    wr(10'h202, 16'h0003);
    sync(1);
    chk(laddr(1) == 8'd64, "R10 rejected write left field", laddr(1), 64);
    sync(0);
    chk(laddr(0) == 8'd32, "R11 same-bank field used", laddr(0), 32);
    // R2 transmit lane reads transmit half
    sync(4);
    chk(lane_data[4*16 +: 16] == 16'h0A00, "R2 transmit half", lane_data[4*16 +: 16], 16'h0A00);

    // random phase, checked by the model every cycle
    for (int k = 0; k < 6000; k++) begin
      for (int l = 0; l < 8; l++) begin
        lane_ready[l] = ($urandom_range(0, 3) != 0);
        lane_fsync[l] = ($urandom_range(0, 9) == 0);
      end
      case ($urandom_range(0, 19))
        0: begin wr_en = 1'b1; wr_addr = {1'b1, 7'd0, 1'b0, 1'($urandom_range(0, 1))};
                 wr_data = good_alt(); end
        1: begin wr_en = 1'b1; wr_addr = {1'b1, 7'd0, 1'b0, 1'($urandom_range(0, 1))};
                 wr_data = 16'($urandom); end
        2: begin wr_en = 1'b1; wr_addr = 10'h202; wr_data = 16'($urandom_range(0, 255)); end
        3, 4: begin wr_en = 1'b1; wr_addr = {1'b0, 9'($urandom)};
                 wr_data = {($urandom_range(0, 5) == 0), 15'($urandom)}; end
        default: wr_en = 1'b0;
      endcase
      tick();
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule